// File: doc/BRIEF.md
# Serial Clock-and-Parameter-RAM Slave

This block is the slave side of a three-wire serial link to a real-time clock with a small parameter memory. A host drives a select line, a serial clock and a data-in line by toggling bits in one of its control registers. The block answers on a single data-out line. All three host lines are sampled with the block's own system clock, and a serial clock edge counts when it goes from high to low.

A transaction has sixteen clock bits. The first eight are a command byte and the last eight are a data byte. The command picks one of these actions: read or write a byte of the 32-byte parameter RAM, read the status or control register, read one of six calendar/time fields as packed BCD, or clear the flag bits of the status register. Timekeeping is not done here. The six time values come in on input ports as binary numbers, and the block converts them to BCD when they are read. An interrupt output stays high while either flag bit of the status register is set.

Top module: `rtc_serial_slave`

## Requirements
- R1: A serial clock falling edge counts only while `ce_i` is high. With `ce_i` low, the frame is abandoned: the bit position goes back to zero, the command and data shift registers are cleared and `sdo_o` goes to 0. Edges seen while `ce_i` is low start nothing.
- R2: The first eight counted edges shift the command in MSB first, and `sdo_o` stays 0 during them. Edges 9 to 16 shift the data byte in MSB first. On each of these edges `sdo_o` presents the next bit of the selected read byte, MSB first, so edge 9 gives bit 7 and edge 16 gives bit 0.
- R3: Commands 0x00–0x1F read RAM byte [command].
- R4: Commands 0x80–0x9F write the received data byte into RAM byte [command − 0x80]. The write happens on the 16th counted edge.
- R5: Command 0x30 reads the status register, which resets to 0x90. Command 0x31 reads the control register, which holds the parameter `CTRL_VALUE` (default 0x5A).
- R6: The time fields are read as packed BCD with the tens digit in bits 7:4. The commands are 0x20 for seconds, 0x21 for minutes, 0x22 for hours, 0x24 for day of month, 0x25 for month and 0x26 for two-digit year.
- R7: `irq_o` is high exactly when status bit 4 or bit 3 is set. A completed command 0xB1 whose data byte has bit 2 set clears status bits 4 and 3, which drops `irq_o`. A 0xB1 frame with data bit 2 clear changes nothing.
- R8: At reset, RAM byte i is loaded with ((i × 29) mod 256) XOR 0xA5.
- R9: Any other command code reads 0 on `sdo_o` and writes nothing. Examples are 0x23, 0x27–0x2F, 0x32–0x7F and 0xA0–0xFF other than 0xB1.
- R10: Counted-edge candidates after the 16th are ignored until `ce_i` goes low. `sdo_o` holds its last bit and no write is repeated.
- R11: A frame abandoned before its 16th counted edge writes nothing. This includes a frame where `ce_i` falls in the same system clock cycle as the 16th serial clock fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Transaction select from host |
| sclk_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| sec_i | input | 7 | Seconds, binary 0–59 |
| min_i | input | 7 | Minutes, binary 0–59 |
| hour_i | input | 7 | Hours, binary 0–23 |
| mday_i | input | 7 | Day of month, binary 1–31 |
| month_i | input | 7 | Month, binary 1–12 |
| year_i | input | 7 | Two-digit year, binary 0–99 |
| sdo_o | output | 1 | Serial data to host |
| irq_o | output | 1 | Flag interrupt request |

## Verification
Two events can arrive in the same system clock cycle: the abort caused by `ce_i` dropping, and the 16th serial clock fall that would commit a RAM write. The bench lowers `ce_i` and `sclk_i` together on the 16th bit of a write frame. It then reads the target byte back and expects the value it had before, because the abort must win. A second collision is edges after the 16th arriving while the frame is still selected. This is judged by checking that `sdo_o` keeps the last bit, and that a later read shows a single write with the original data.

// File: rtl/rtcs_pkg.sv
package rtcs_pkg;
    localparam int BYTE_W      = 8;
    localparam int RAM_DEPTH   = 32;
    localparam int ADDR_W      = $clog2(RAM_DEPTH);
    localparam int CMD_BITS    = 8;
    localparam int FRAME_BITS  = 16;
    localparam int PH_W        = $clog2(FRAME_BITS + 1);
    localparam int TIME_W      = 7;
    localparam int TIME_FIELDS = 6;

    typedef struct packed {
        logic [PH_W-1:0]   phase;
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] val;
        logic [BYTE_W-1:0] rd;
        logic              sdo;
        logic              sclk_prev;
    } shift_st_t;

    function automatic logic [BYTE_W-1:0] ram_default(input int idx);
        int mixed;
        mixed = (idx * 29) ^ 8'hA5;
        return BYTE_W'(mixed);
    endfunction

    function automatic logic [BYTE_W-1:0] to_bcd(input logic [TIME_W-1:0] v);
        logic [TIME_W-1:0] tens;
        logic [TIME_W-1:0] ones;
        tens = v / TIME_W'(10);
        ones = v % TIME_W'(10);
        return {tens[3:0], ones[3:0]};
    endfunction
endpackage

// File: rtl/rtcs_shifter.sv
module rtcs_shifter
    import rtcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic [BYTE_W-1:0] rd_byte_i,
    output logic [BYTE_W-1:0] cmd_o,
    output logic              commit_o,
    output logic [BYTE_W-1:0] wr_byte_o,
    output logic              sdo_o
);
    localparam logic [PH_W-1:0] PH_CMD_END = PH_W'(CMD_BITS);
    localparam logic [PH_W-1:0] PH_LAST    = PH_W'(FRAME_BITS - 1);
    localparam logic [PH_W-1:0] PH_DONE    = PH_W'(FRAME_BITS);

    shift_st_t q, d;
    logic      fall;
    logic      commit_d;

    always_comb begin
        d        = q;
        commit_d = 1'b0;
        fall     = q.sclk_prev & ~sclk_i;
        d.sclk_prev = sclk_i;
        if (!ce_i) begin
            d.phase = '0;
            d.cmd   = '0;
            d.val   = '0;
            d.rd    = '0;
            d.sdo   = 1'b0;
        end else if (fall && (q.phase < PH_DONE)) begin
            d.phase = q.phase + 1'b1;
            if (q.phase < PH_CMD_END) begin
                d.cmd = {q.cmd[BYTE_W-2:0], sdi_i};
            end else begin
                d.val = {q.val[BYTE_W-2:0], sdi_i};
                if (q.phase == PH_CMD_END) begin
                    d.sdo = rd_byte_i[BYTE_W-1];
                    d.rd  = {rd_byte_i[BYTE_W-2:0], 1'b0};
                end else begin
                    d.sdo = q.rd[BYTE_W-1];
                    d.rd  = {q.rd[BYTE_W-2:0], 1'b0};
                end
                if (q.phase == PH_LAST) begin
                    commit_d = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cmd_o     = q.cmd;
    assign commit_o  = commit_d;
    assign wr_byte_o = {q.val[BYTE_W-2:0], sdi_i};
    assign sdo_o     = q.sdo;

    // R1: deselect abandons the frame on the next cycle
    assert_abort_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_i |=> (q.phase == '0 && !sdo_o && q.cmd == '0));

    // R2: no output bit before the data half of the frame
    assert_quiet_cmd_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase <= PH_CMD_END) |-> !sdo_o);

    // R10: bit position never runs past the end of the frame
    assert_phase_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.phase <= PH_DONE);

    // R10: finished frame is frozen while still selected
    assert_done_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_DONE && ce_i) |=> (q.phase == PH_DONE && $stable(sdo_o) && !commit_o));
endmodule

// File: rtl/rtcs_regs.sv
module rtcs_regs
    import rtcs_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CTRL_VALUE   = 8'h5A,
    parameter logic [BYTE_W-1:0] STATUS_RESET = 8'h90
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [BYTE_W-1:0]                  cmd_i,
    input  logic                               commit_i,
    input  logic [BYTE_W-1:0]                  wr_byte_i,
    input  logic [TIME_FIELDS-1:0][TIME_W-1:0] time_i,
    output logic [BYTE_W-1:0]                  rd_byte_o,
    output logic                               irq_o
);
    localparam logic [BYTE_W-1:0] FLAG_MASK = 8'h18;
    localparam logic [BYTE_W-1:0] CMD_CLEAR = 8'hB1;
    localparam logic [BYTE_W-1:0] CMD_STAT  = 8'h30;
    localparam logic [BYTE_W-1:0] CMD_CTRL  = 8'h31;

    typedef struct {
        logic [BYTE_W-1:0] ram [RAM_DEPTH];
        logic [BYTE_W-1:0] status;
    } regs_st_t;

    regs_st_t q, d;
    logic [TIME_FIELDS-1:0][BYTE_W-1:0] bcd;
    logic                               is_write;
    logic [ADDR_W-1:0]                  addr;

    for (genvar g = 0; g < TIME_FIELDS; g++) begin : g_bcd
        assign bcd[g] = to_bcd(time_i[g]);
    end

    assign addr     = cmd_i[ADDR_W-1:0];
    assign is_write = (cmd_i[BYTE_W-1:ADDR_W] == 3'b100);

    always_comb begin
        rd_byte_o = '0;
        if (cmd_i[BYTE_W-1:ADDR_W] == 3'b000) begin
            rd_byte_o = q.ram[addr];
        end else begin
            case (cmd_i)
                8'h20:    rd_byte_o = bcd[0];
                8'h21:    rd_byte_o = bcd[1];
                8'h22:    rd_byte_o = bcd[2];
                8'h24:    rd_byte_o = bcd[3];
                8'h25:    rd_byte_o = bcd[4];
                8'h26:    rd_byte_o = bcd[5];
                CMD_STAT: rd_byte_o = q.status;
                CMD_CTRL: rd_byte_o = CTRL_VALUE;
                default:  rd_byte_o = '0;
            endcase
        end
    end

    always_comb begin
        d = q;
        if (commit_i) begin
            if (is_write) begin
                d.ram[addr] = wr_byte_i;
            end
            if (cmd_i == CMD_CLEAR && wr_byte_i[2]) begin
                d.status = q.status & ~FLAG_MASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RAM_DEPTH; i++) begin
                q.ram[i] <= ram_default(i);
            end
            q.status <= STATUS_RESET;
        end else begin
            q <= d;
        end
    end

    assign irq_o = |(q.status & FLAG_MASK);

    // R7: status flags can only be cleared, never set
    assert_status_clear_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.status & ~$past(q.status)) == '0);

    // R7: a clear command with bit 2 set drops the request
    assert_clear_drops_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && cmd_i == CMD_CLEAR && wr_byte_i[2]) |=> !irq_o);

    // R4: a committed write lands in the addressed byte
    assert_ram_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && is_write) |=> (q.ram[$past(addr)] == $past(wr_byte_i)));
endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
    import rtcs_pkg::*;
#(
    parameter logic [7:0] CTRL_VALUE   = 8'h5A,
    parameter logic [7:0] STATUS_RESET = 8'h90
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_i,
    input  logic       sclk_i,
    input  logic       sdi_i,
    input  logic [6:0] sec_i,
    input  logic [6:0] min_i,
    input  logic [6:0] hour_i,
    input  logic [6:0] mday_i,
    input  logic [6:0] month_i,
    input  logic [6:0] year_i,
    output logic       sdo_o,
    output logic       irq_o
);
    logic [BYTE_W-1:0]                  cmd;
    logic [BYTE_W-1:0]                  wr_byte;
    logic [BYTE_W-1:0]                  rd_byte;
    logic                               commit;
    logic [TIME_FIELDS-1:0][TIME_W-1:0] time_bin;

    assign time_bin = {year_i, month_i, mday_i, hour_i, min_i, sec_i};

    rtcs_shifter u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_i      (ce_i),
        .sclk_i    (sclk_i),
        .sdi_i     (sdi_i),
        .rd_byte_i (rd_byte),
        .cmd_o     (cmd),
        .commit_o  (commit),
        .wr_byte_o (wr_byte),
        .sdo_o     (sdo_o)
    );

    rtcs_regs #(
        .CTRL_VALUE   (CTRL_VALUE),
        .STATUS_RESET (STATUS_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd),
        .commit_i  (commit),
        .wr_byte_i (wr_byte),
        .time_i    (time_bin),
        .rd_byte_o (rd_byte),
        .irq_o     (irq_o)
    );
endmodule

// File: tb/rtc_serial_slave_bench.sv
module rtc_serial_slave_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic [6:0] sec = 0, mins = 0, hour = 0, mday = 1, month = 1, year = 0;
    logic       sdo, irq;

    int         checks = 0;
    int         failures = 0;
    bit         done = 0;
    logic [7:0] ram_m [32];
    logic [7:0] status_m;

    always #10 clk = ~clk;

    rtc_serial_slave u_rtc_serial_slave (
        .clk(clk), .rst_n(rst_n), .ce_i(ce), .sclk_i(sclk), .sdi_i(sdi),
        .sec_i(sec), .min_i(mins), .hour_i(hour), .mday_i(mday),
        .month_i(month), .year_i(year), .sdo_o(sdo), .irq_o(irq)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] c);
        if (c < 8'h20) return ram_m[c[4:0]];
        case (c)
            8'h20: return bcd(int'(sec));
            8'h21: return bcd(int'(mins));
            8'h22: return bcd(int'(hour));
            8'h24: return bcd(int'(mday));
            8'h25: return bcd(int'(month));
            8'h26: return bcd(int'(year));
            8'h30: return status_m;
            8'h31: return 8'h5A;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ce = 0; sclk = 0; sdi = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 32; i++) ram_m[i] = 8'(((i * 29) ^ 8'hA5));
        status_m = 8'h90;
        @(negedge clk);
    endtask

    // Drives nbits counted edges (MSB first), optional extra edges, then
    // deselects. quiet reports whether sdo stayed 0 in the command half.
    task automatic frame(input logic [7:0] c, input logic [7:0] dat, input int nbits,
                         input int extra, output logic [7:0] got, output bit quiet,
                         output bit held);
        got = 8'h00; quiet = 1; held = 1;
        ce = 1'b1;
        @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi  = (i < 8) ? c[7 - i] : dat[15 - i];
            sclk = 1'b1;
            repeat (2) @(negedge clk);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
            if (i < 8) begin
                if (sdo !== 1'b0) quiet = 0;
            end else begin
                got[15 - i] = sdo;
            end
        end
        for (int e = 0; e < extra; e++) begin
            sdi  = ~sdi;
            sclk = 1'b1;
            repeat (2) @(negedge clk);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
            if (sdo !== got[0]) held = 0;
        end
        ce = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] c, input logic [7:0] dat, output logic [7:0] got);
        bit q, h;
        frame(c, dat, 16, 0, got, q, h);
        if (c[7:5] == 3'b100) ram_m[c[4:0]] = dat;
        if (c == 8'hB1 && dat[2]) status_m = status_m & ~8'h18;
    endtask

    task automatic read_check(input string tag, input logic [7:0] c);
        logic [7:0] g;
        xfer(c, 8'h00, g);
        check(tag, g, exp_read(c));
    endtask

    task automatic ram_all_check(input string tag);
        for (int i = 0; i < 32; i++) read_check(tag, 8'(i));
    endtask

    initial begin
        logic [7:0] g;
        bit         q, h;
        int         unused_seed;
        unused_seed = $urandom(32'd20240611);
        do_reset();

        // reset state
        check("R5 reset sdo", {7'b0, sdo}, 8'h00);
        check("R7 reset irq", {7'b0, irq}, 8'h01);

        // R8 default image, R3 reads
        ram_all_check("R8/R3 default RAM");

        // R5 status and control
        read_check("R5 status read", 8'h30);
        read_check("R5 control read", 8'h31);

        // R2 command half quiet, data MSB first
        frame(8'h1F, 8'hFF, 16, 0, g, q, h);
        check("R2 quiet command half", {7'b0, q}, 8'h01);
        check("R2 MSB-first data", g, ram_m[31]);

        // R6 time fields, boundary patterns
        sec = 59; mins = 0; hour = 23; mday = 31; month = 12; year = 99;
        foreach (sec[i]) ;
        for (int k = 0; k < 7; k++) read_check("R6 time hi", 8'h20 + 8'(k));
        sec = 0; mins = 59; hour = 0; mday = 1; month = 1; year = 0;
        for (int k = 0; k < 7; k++) read_check("R6 time lo", 8'h20 + 8'(k));
        for (int n = 0; n < 6; n++) begin
            sec = 7'($urandom_range(59)); mins = 7'($urandom_range(59));
            hour = 7'($urandom_range(23)); mday = 7'($urandom_range(31, 1));
            month = 7'($urandom_range(12, 1)); year = 7'($urandom_range(99));
            read_check("R6 time rand", 8'h20 + 8'($urandom_range(6)));
        end

        // R4 writes, random mix with reads
        for (int n = 0; n < 60; n++) begin
            logic [4:0] a;
            logic [7:0] v;
            a = 5'($urandom);
            v = 8'($urandom);
            if ($urandom_range(1) == 1) xfer({3'b100, a}, v, g);
            else read_check("R3 random read", {3'b000, a});
        end
        xfer(8'h80, 8'h00, g);
        xfer(8'h9F, 8'hFF, g);
        ram_all_check("R4 write readback");

        // R9 unused codes: zero data out, no write
        read_check("R9 unused 0x23", 8'h23);
        read_check("R9 unused 0x2F", 8'h2F);
        read_check("R9 unused 0x32", 8'h32);
        read_check("R9 unused 0x7F", 8'h7F);
        xfer(8'hA3, 8'h3C, g);
        check("R9 unused 0xA3 out", g, 8'h00);
        xfer(8'hFF, 8'hC3, g);
        check("R9 unused 0xFF out", g, 8'h00);
        ram_all_check("R9 no write");

        // R11 abort after 15 bits
        frame(8'h85, ~ram_m[5], 15, 0, g, q, h);
        read_check("R11 abort at bit 15", 8'h05);
        // R11 abort coinciding with the 16th fall
        begin
            logic [7:0] c = 8'h86;
            logic [7:0] dv = ~ram_m[6];
            ce = 1'b1;
            @(negedge clk);
            for (int i = 0; i < 16; i++) begin
                sdi  = (i < 8) ? c[7 - i] : dv[15 - i];
                sclk = 1'b1;
                repeat (2) @(negedge clk);
                sclk = 1'b0;
                if (i == 15) ce = 1'b0;
                repeat (2) @(negedge clk);
            end
            repeat (2) @(negedge clk);
        end
        read_check("R11 abort with 16th edge", 8'h06);
        check("R1 sdo cleared after abort", {7'b0, sdo}, 8'h00);

        // R1 edges with ce low do nothing, next frame aligns
        for (int k = 0; k < 5; k++) begin
            sdi = 1'b1; sclk = 1'b1; repeat (2) @(negedge clk);
            sclk = 1'b0; repeat (2) @(negedge clk);
        end
        read_check("R1 deselected edges ignored", 8'h07);

        // R10 extra edges after 16: sdo held, single write
        frame(8'h0A, 8'h00, 16, 3, g, q, h);
        check("R10 sdo held after frame", {7'b0, h}, 8'h01);
        check("R10 read with extra edges", g, ram_m[10]);
        frame(8'h8B, 8'h5D, 16, 4, g, q, h);
        ram_m[11] = 8'h5D;
        read_check("R10 no repeated write", 8'h0B);

        // R7 clear command
        xfer(8'hB1, 8'hFB, g);
        read_check("R7 bit2 clear no effect", 8'h30);
        check("R7 irq kept", {7'b0, irq}, 8'h01);
        xfer(8'hB1, 8'h04, g);
        read_check("R7 flags cleared", 8'h30);
        check("R7 irq dropped", {7'b0, irq}, 8'h00);

        do_reset();
        read_check("R5 status after reset", 8'h30);
        check("R7 irq after reset", {7'b0, irq}, 8'h01);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule